// File: doc/BRIEF.md
# Control-Word Driven Register Datapath

This block is the execution half of a small processor: a file of eight 8-bit registers, two operand buses, a function unit for add, subtract and bitwise work, a one-bit shifter, and a result selector that feeds a single write port. It does no decoding of its own. Every cycle an outside controller presents a control word, and the datapath carries out the register transfer that word describes within that cycle. The destination is written on the next rising clock edge.

The control word has separate fields. Two fields pick the registers that drive buses A and B. One bit swaps bus B for an outside constant. A 4-bit code picks the function-unit operation. A 2-bit code picks what gets written back: the function-unit result, bus B shifted right, bus B shifted left, or data returned from memory. A destination index and a load enable complete the word. Bus A leaves the block as a memory address and bus B as memory write data, so loads and stores need no extra paths.

Top module: `cw_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears all eight registers and both flags at the rising edge.
- R2: `mem_addr` always equals the register named by `a_sel`, and when `use_const` is 0, `mem_wdata` equals the register named by `b_sel`.
- R3: When `use_const` is 1, bus B (`mem_wdata`) carries `const_in` in place of a register.
- R4: Arithmetic `fn_sel` codes: 1 = A+B, 2 = A+B+1, 3 = A+~B+1 (A minus B), 4 = A+1, 5 = A-1 (A plus all ones). Each result is taken modulo 256.
- R5: For codes 1 to 5, `carry_o` captures the carry out of bit 7 of the addition above, and `ovf_o` captures signed overflow. Signed overflow means both adder inputs have the same sign and the sum has a different one.
- R6: Non-arithmetic `fn_sel` codes: 0 = pass A, 6 = AND, 7 = OR, 8 = XOR, 9 = NOT A, and 10 to 15 also pass A. These codes clear both flags when loaded.
- R7: `res_sel` 1 writes bus B shifted right by one and `res_sel` 2 writes bus B shifted left by one. The bit shifted out is lost and a zero enters.
- R8: `res_sel` 3 writes `mem_din` into the destination; `res_sel` 0 writes the function-unit result.
- R9: When `load_en` is 0, no register changes and both flags hold their values.
- R10: When `load_en` is 1, the selected result is written into register `dst_sel` at the next rising edge, together with the flags from the function unit. It can be read on bus A in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a_sel | input | 3 | Register driving bus A |
| b_sel | input | 3 | Register driving bus B |
| use_const | input | 1 | 1 selects `const_in` for bus B |
| const_in | input | 8 | Outside constant operand |
| fn_sel | input | 4 | Function-unit operation code |
| res_sel | input | 2 | Write-back source: 0 function, 1 shift right, 2 shift left, 3 memory |
| dst_sel | input | 3 | Destination register index |
| load_en | input | 1 | Write enable for destination and flags |
| mem_din | input | 8 | Data returned from memory |
| mem_addr | output | 8 | Bus A, used as memory address |
| mem_wdata | output | 8 | Bus B, used as memory write data |
| carry_o | output | 1 | Registered carry flag |
| ovf_o | output | 1 | Registered signed-overflow flag |

## Verification
The arithmetic codes use operand pairs picked so that carry and overflow come out differently. One positive sum overflows without a carry, and subtraction is run in both orders to show borrow against no borrow. Incrementing 0xFF and decrementing 0x80 test the wrap cases. The logic codes use 0x35 and 0x5A, which have bits in all four AND/OR combinations, so a swapped operation gives a different byte. The shifter uses 0x81 so that the lost end bit and the zero fill can both be seen. A cycle with load disabled follows a cycle that set the flags, which shows that neither the register nor the flags moved.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
    typedef enum logic [3:0] {
        FN_PASS = 4'd0,
        FN_ADD  = 4'd1,
        FN_ADDC = 4'd2,
        FN_SUB  = 4'd3,
        FN_INC  = 4'd4,
        FN_DEC  = 4'd5,
        FN_AND  = 4'd6,
        FN_OR   = 4'd7,
        FN_XOR  = 4'd8,
        FN_NOT  = 4'd9
    } fn_e;

    typedef enum logic [1:0] {
        RES_FUNC = 2'd0,
        RES_SHR  = 2'd1,
        RES_SHL  = 2'd2,
        RES_MEM  = 2'd3
    } res_e;

    typedef struct packed {
        logic carry;
        logic ovf;
    } flags_t;
endpackage

// File: rtl/cwd_regfile.sv
module cwd_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_a_idx,
    input  logic [AW-1:0] rd_b_idx,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b
);
    logic [DW-1:0] regs_d [NREG];
    logic [DW-1:0] regs_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_comb begin
            regs_d[i] = regs_q[i];
            if (rst) begin
                regs_d[i] = '0;
            end else if (wr_en && (wr_idx == AW'(i))) begin
                regs_d[i] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            regs_q[i] <= regs_d[i];
        end
    end

    assign rd_a = regs_q[rd_a_idx];
    assign rd_b = regs_q[rd_b_idx];
endmodule

// File: rtl/cwd_func_unit.sv
module cwd_func_unit
    import cwd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [3:0]    fn,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic [DW-1:0] result,
    output flags_t        flags
);
    logic [DW-1:0] addend;
    logic          cin;
    logic          arith;
    logic [DW:0]   sum;

    always_comb begin
        arith  = 1'b1;
        addend = op_b;
        cin    = 1'b0;
        unique case (fn_e'(fn))
            FN_ADD:  begin addend = op_b;         cin = 1'b0; end
            FN_ADDC: begin addend = op_b;         cin = 1'b1; end
            FN_SUB:  begin addend = ~op_b;        cin = 1'b1; end
            FN_INC:  begin addend = '0;           cin = 1'b1; end
            FN_DEC:  begin addend = {DW{1'b1}};   cin = 1'b0; end
            default: begin addend = '0;           arith = 1'b0; end
        endcase

        sum = {1'b0, op_a} + {1'b0, addend} + {{DW{1'b0}}, cin};

        case (fn_e'(fn))
            FN_AND:  result = op_a & op_b;
            FN_OR:   result = op_a | op_b;
            FN_XOR:  result = op_a ^ op_b;
            FN_NOT:  result = ~op_a;
            default: result = arith ? sum[DW-1:0] : op_a;
        endcase

        flags.carry = arith & sum[DW];
        flags.ovf   = arith & (op_a[DW-1] == addend[DW-1]) & (sum[DW-1] != op_a[DW-1]);
    end
endmodule

// File: rtl/cwd_shifter.sv
module cwd_shifter #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] din,
    output logic [DW-1:0] right,
    output logic [DW-1:0] left
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (i == DW - 1) begin : g_top
            assign right[i] = 1'b0;
        end else begin : g_mid
            assign right[i] = din[i+1];
        end
        if (i == 0) begin : g_bot
            assign left[i] = 1'b0;
        end else begin : g_low
            assign left[i] = din[i-1];
        end
    end
endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
    import cwd_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] a_sel,
    input  logic [AW-1:0] b_sel,
    input  logic          use_const,
    input  logic [DW-1:0] const_in,
    input  logic [3:0]    fn_sel,
    input  logic [1:0]    res_sel,
    input  logic [AW-1:0] dst_sel,
    input  logic          load_en,
    input  logic [DW-1:0] mem_din,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          carry_o,
    output logic          ovf_o
);
    logic [DW-1:0] bus_a, reg_b, bus_b;
    logic [DW-1:0] fu_res, shr_res, shl_res, wb_data;
    flags_t        fu_flags, flags_d, flags_q;

    cwd_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (a_sel),
        .rd_b_idx (b_sel),
        .wr_en    (load_en),
        .wr_idx   (dst_sel),
        .wr_data  (wb_data),
        .rd_a     (bus_a),
        .rd_b     (reg_b)
    );

    assign bus_b = use_const ? const_in : reg_b;

    cwd_func_unit #(.DW(DW)) u_fu (
        .fn     (fn_sel),
        .op_a   (bus_a),
        .op_b   (bus_b),
        .result (fu_res),
        .flags  (fu_flags)
    );

    cwd_shifter #(.DW(DW)) u_sh (
        .din   (bus_b),
        .right (shr_res),
        .left  (shl_res)
    );

    always_comb begin
        unique case (res_e'(res_sel))
            RES_SHR: wb_data = shr_res;
            RES_SHL: wb_data = shl_res;
            RES_MEM: wb_data = mem_din;
            default: wb_data = fu_res;
        endcase

        flags_d = flags_q;
        if (rst) begin
            flags_d = '0;
        end else if (load_en) begin
            flags_d = fu_flags;
        end
    end

    always_ff @(posedge clk) begin
        flags_q <= flags_d;
    end

    assign mem_addr  = bus_a;
    assign mem_wdata = bus_b;
    assign carry_o   = flags_q.carry;
    assign ovf_o     = flags_q.ovf;
endmodule

// File: rtl/cw_datapath_chk.sv
module cw_datapath_chk #(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] a_sel,
    input logic [AW-1:0] dst_sel,
    input logic          use_const,
    input logic [DW-1:0] const_in,
    input logic [3:0]    fn_sel,
    input logic [1:0]    res_sel,
    input logic          load_en,
    input logic [DW-1:0] mem_din,
    input logic [DW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          carry_o,
    input logic          ovf_o
);
    AST_CONST_ON_B: assert property (@(posedge clk) disable iff (rst)
        use_const |-> (mem_wdata == const_in)); // R3

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable({carry_o, ovf_o})); // R9

    AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (load_en && fn_sel >= 4'd6) |=> (!carry_o && !ovf_o)); // R6

    AST_MEM_LOAD: assert property (@(posedge clk) disable iff (rst)
        (load_en && res_sel == 2'd3) |=>
            ((a_sel != $past(dst_sel)) || (mem_addr == $past(mem_din)))); // R8

    AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (rst)
        (load_en && res_sel == 2'd2) |=>
            ((a_sel != $past(dst_sel)) || (mem_addr == {$past(mem_wdata[DW-2:0]), 1'b0}))); // R7
endmodule

bind cw_datapath cw_datapath_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .a_sel     (a_sel),
    .dst_sel   (dst_sel),
    .use_const (use_const),
    .const_in  (const_in),
    .fn_sel    (fn_sel),
    .res_sel   (res_sel),
    .load_en   (load_en),
    .mem_din   (mem_din),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .carry_o   (carry_o),
    .ovf_o     (ovf_o)
);

// File: tb/cw_datapath_test.sv
`timescale 1ns/1ps
module cw_datapath_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] a_sel, b_sel, dst_sel;
    logic       use_const, load_en;
    logic [7:0] const_in, mem_din;
    logic [3:0] fn_sel;
    logic [1:0] res_sel;
    logic [7:0] mem_addr, mem_wdata;
    logic       carry_o, ovf_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cw_datapath uut (
        .clk(clk), .rst(rst), .a_sel(a_sel), .b_sel(b_sel),
        .use_const(use_const), .const_in(const_in), .fn_sel(fn_sel),
        .res_sel(res_sel), .dst_sel(dst_sel), .load_en(load_en),
        .mem_din(mem_din), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .carry_o(carry_o), .ovf_o(ovf_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input logic [2:0] idx, input logic [7:0] exp, input string tag);
        a_sel = idx;
        #0.5;
        chk(tag, mem_addr, exp);
    endtask

    task automatic chk_flags(input logic c, input logic v, input string tag);
        chk({tag, " carry"}, {7'd0, carry_o}, {7'd0, c});
        chk({tag, " ovf"},   {7'd0, ovf_o},   {7'd0, v});
    endtask

    task automatic do_op(input logic [2:0] a, input logic [2:0] b, input logic uc,
                         input logic [7:0] k, input logic [3:0] fn, input logic [1:0] rs,
                         input logic [2:0] d, input logic ld, input logic [7:0] md);
        @(negedge clk);
        a_sel = a; b_sel = b; use_const = uc; const_in = k;
        fn_sel = fn; res_sel = rs; dst_sel = d; load_en = ld; mem_din = md;
        @(posedge clk);
        #0.5;
        load_en = 1'b0;
        use_const = 1'b0;
    endtask

    task automatic write_reg(input logic [2:0] d, input logic [7:0] v);
        do_op(3'd0, 3'd0, 1'b0, 8'h00, 4'd0, 2'd3, d, 1'b1, v);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 8; i++) read_reg(3'(i), 8'h00, "R1 reset reg");
        chk_flags(1'b0, 1'b0, "R1 reset");
    endtask

    task automatic t_buses;
        write_reg(3'd1, 8'h35);
        read_reg(3'd1, 8'h35, "R8 mem load r1 / R10");
        write_reg(3'd2, 8'h5A);
        a_sel = 3'd2; b_sel = 3'd1; use_const = 1'b0; #0.5;
        chk("R2 bus A", mem_addr, 8'h5A);
        chk("R2 bus B", mem_wdata, 8'h35);
        use_const = 1'b1; const_in = 8'hC3; #0.5;
        chk("R3 const on B", mem_wdata, 8'hC3);
        use_const = 1'b0;
    endtask

    task automatic t_arith;
        do_op(3'd1, 3'd2, 1'b0, 8'h00, 4'd1, 2'd0, 3'd3, 1'b1, 8'h00);
        chk_flags(1'b0, 1'b1, "R5 add");
        read_reg(3'd3, 8'h8F, "R4 add / R10");
        do_op(3'd1, 3'd2, 1'b0, 8'h00, 4'd2, 2'd0, 3'd3, 1'b1, 8'h00);
        read_reg(3'd3, 8'h90, "R4 add plus one");
        do_op(3'd2, 3'd1, 1'b0, 8'h00, 4'd3, 2'd0, 3'd4, 1'b1, 8'h00);
        chk_flags(1'b1, 1'b0, "R5 sub no borrow");
        read_reg(3'd4, 8'h25, "R4 sub");
        do_op(3'd1, 3'd2, 1'b0, 8'h00, 4'd3, 2'd0, 3'd4, 1'b1, 8'h00);
        chk_flags(1'b0, 1'b0, "R5 sub borrow");
        read_reg(3'd4, 8'hDB, "R4 sub negative");
        do_op(3'd1, 3'd0, 1'b1, 8'h10, 4'd1, 2'd0, 3'd6, 1'b1, 8'h00);
        read_reg(3'd6, 8'h45, "R3 add constant");
        write_reg(3'd5, 8'hFF);
        do_op(3'd5, 3'd0, 1'b0, 8'h00, 4'd4, 2'd0, 3'd5, 1'b1, 8'h00);
        chk_flags(1'b1, 1'b0, "R5 inc wrap");
        read_reg(3'd5, 8'h00, "R4 inc wrap");
        write_reg(3'd5, 8'h80);
        do_op(3'd5, 3'd0, 1'b0, 8'h00, 4'd5, 2'd0, 3'd5, 1'b1, 8'h00);
        chk_flags(1'b1, 1'b1, "R5 dec 80");
        read_reg(3'd5, 8'h7F, "R4 dec 80");
    endtask

    task automatic t_hold;
        do_op(3'd1, 3'd2, 1'b0, 8'h00, 4'd7, 2'd0, 3'd5, 1'b0, 8'h00);
        chk_flags(1'b1, 1'b1, "R9 flags hold");
        read_reg(3'd5, 8'h7F, "R9 reg hold");
    endtask

    task automatic t_logic;
        do_op(3'd1, 3'd2, 1'b0, 8'h00, 4'd6, 2'd0, 3'd7, 1'b1, 8'h00);
        chk_flags(1'b0, 1'b0, "R6 flags clear");
        read_reg(3'd7, 8'h10, "R6 and");
        do_op(3'd1, 3'd2, 1'b0, 8'h00, 4'd7, 2'd0, 3'd7, 1'b1, 8'h00);
        read_reg(3'd7, 8'h7F, "R6 or");
        do_op(3'd1, 3'd2, 1'b0, 8'h00, 4'd8, 2'd0, 3'd7, 1'b1, 8'h00);
        read_reg(3'd7, 8'h6F, "R6 xor");
        do_op(3'd1, 3'd2, 1'b0, 8'h00, 4'd9, 2'd0, 3'd7, 1'b1, 8'h00);
        read_reg(3'd7, 8'hCA, "R6 not");
        do_op(3'd2, 3'd1, 1'b0, 8'h00, 4'd0, 2'd0, 3'd7, 1'b1, 8'h00);
        read_reg(3'd7, 8'h5A, "R6 pass");
        do_op(3'd1, 3'd2, 1'b0, 8'h00, 4'd12, 2'd0, 3'd7, 1'b1, 8'h00);
        read_reg(3'd7, 8'h35, "R6 spare code passes A");
    endtask

    task automatic t_shift;
        do_op(3'd0, 3'd0, 1'b1, 8'h81, 4'd1, 2'd1, 3'd6, 1'b1, 8'h00);
        read_reg(3'd6, 8'h40, "R7 shift right");
        do_op(3'd0, 3'd0, 1'b1, 8'h81, 4'd1, 2'd2, 3'd6, 1'b1, 8'h00);
        read_reg(3'd6, 8'h02, "R7 shift left");
    endtask

    task automatic t_rst_again;
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #0.5; rst = 1'b0;
        read_reg(3'd1, 8'h00, "R1 reset after use");
    endtask

    initial begin
        rst = 1'b1; a_sel = '0; b_sel = '0; dst_sel = '0; use_const = 1'b0;
        load_en = 1'b0; const_in = '0; mem_din = '0; fn_sel = '0; res_sel = '0;
        repeat (3) @(posedge clk);
        #0.5; rst = 1'b0;
        t_reset;
        t_buses;
        t_arith;
        t_hold;
        t_logic;
        t_shift;
        t_rst_again;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule